// File: doc/BRIEF.md
# Diagnostic Serial Transceiver with Channel Routing Modes

This block is a full-duplex asynchronous serial transceiver for bring-up and diagnostic consoles. Frames carry a start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. A programmable divisor produces a tick at sixteen times the baud rate. The block holds one character for transmission and one received character. It flags overrun, parity and framing errors, and it raises a single maskable interrupt.

A two-bit routing field connects the serial pins and the internal shifters in one of four ways. Normal mode is the usual operation. Echo mode copies the receive pin back out while the receiver keeps working. Local loopback feeds the transmitter into the receiver and parks the output pin high. Remote loopback wires the receive pin straight to the output pin and idles the receiver. A command strobe vector resets, enables or disables each direction on its own and clears the error flags.

Top module: `dbg_uart`

## Requirements
- R1: One serial bit lasts 16 x `cfg_div` clock cycles. When `cfg_div` is 0 no tick is produced, so a written character stays in the holding register (`status[1]` stays 0) and `txd` stays 1.
- R2: A transmitted frame is a 0 start bit, 8 data bits LSB first, a parity bit when parity is enabled, and a 1 stop bit. `status[1]` (transmit ready) is 1 whenever the holding register is empty. A write while it is 0 is dropped.
- R3: `cfg_par` selects the parity bit: 0 even (bit = XOR of data), 1 odd (inverse XOR), 2 always 0, 3 always 1, 4 to 7 no parity bit. The transmitter and the receiver use the same encoding.
- R4: The receiver detects a falling edge, confirms the start bit at mid-bit, and samples each data bit at its centre. On the stop bit it loads `rx_data` and sets `status[0]` (receive ready). A one-cycle `rx_rd` pulse clears `status[0]`.
- R5: A stop-bit sample of 0 sets `status[3]` (framing error). The character is still delivered.
- R6: A received parity bit that differs from the R3 value sets `status[4]` (parity error).
- R7: A character that completes while `status[0]` is still 1 sets `status[2]` (overrun). `rx_data` then holds the newest character.
- R8: With `cfg_chan` = 2 (local loopback), the transmitter drives the receiver internally, `txd` is held at 1 and `rxd` is ignored.
- R9: With `cfg_chan` = 1 (echo), `rxd` is copied to `txd` and the receiver still receives. With `cfg_chan` = 3 (remote loopback), `rxd` is copied to `txd` and the receiver gets nothing. With `cfg_chan` = 0, `txd` carries the transmitter.
- R10: The `cmd` bits act as one-cycle strobes: bit0 resets the receiver, bit1 resets the transmitter, bit2 enables the receiver, bit3 disables the receiver, bit4 enables the transmitter, bit5 disables the transmitter. A reset also disables its direction, and disable wins over enable. A disabled receiver ignores frames. A disabled transmitter keeps its character. A transmitter reset drops that character.
- R11: Strobe bit6 of `cmd` clears `status[4:2]`. Error flags are sticky until this strobe or a receiver reset.
- R12: `irq` is the registered OR of `status & irq_mask`, one cycle behind `status`.
- R13: After `rst`, both directions are disabled, `txd` is 1, `status` is 5'b00010 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Baud divisor; 0 stops the tick |
| cfg_par | input | 3 | Parity selection (R3) |
| cfg_chan | input | 2 | Routing mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| irq_mask | input | 5 | Interrupt enable per status bit |
| cmd | input | 7 | Command strobes (R10, R11) |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | DATA_W | Character to transmit |
| rx_rd | input | 1 | Read strobe; clears receive ready |
| rx_data | output | DATA_W | Last received character |
| status | output | 5 | {parity err, framing err, overrun, tx ready, rx ready} |
| irq | output | 1 | Masked interrupt |
| rxd | input | 1 | Serial input pin |
| txd | output | 1 | Serial output pin |

## Verification
The bench varies the divisor and checks bit periods at two divisor values. A divisor that is off by one misplaces the sample points and corrupts the bit sequence that is captured. It checks every parity encoding in both directions, so a swapped even and odd selection or a parity bit emitted in no-parity mode shows up as wrong data or a false parity error. Overrun, framing errors with a low stop bit, and the same-cycle enable-plus-disable strobe are targeted directly. A design that overwrote without flagging, dropped the bad-stop character, or let enable win would report a wrong status. Each routing mode is run with a hostile level on the unused pin, so a leaky multiplexer shows up as `txd` activity or as a spurious received character.

// File: rtl/dbg_uart_pkg.sv
package dbg_uart_pkg;

  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chan_mode_e;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_PAR,
    FR_STOP
  } frame_st_e;

  // command strobe positions
  localparam int CMD_RX_RST = 0;
  localparam int CMD_TX_RST = 1;
  localparam int CMD_RX_EN  = 2;
  localparam int CMD_RX_DIS = 3;
  localparam int CMD_TX_EN  = 4;
  localparam int CMD_TX_DIS = 5;
  localparam int CMD_ST_CLR = 6;
  localparam int CMD_W      = 7;

  // status bit positions
  localparam int ST_RXRDY = 0;
  localparam int ST_TXRDY = 1;
  localparam int ST_OVR   = 2;
  localparam int ST_FRM   = 3;
  localparam int ST_PAR   = 4;
  localparam int ST_W     = 5;

  function automatic logic par_enabled(input logic [2:0] mode);
    return (mode < 3'd4);
  endfunction

  function automatic logic par_value(input logic [2:0] mode, input logic dxor);
    case (mode)
      3'd0:    return dxor;
      3'd1:    return ~dxor;
      3'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dbg_uart_baud.sv
module dbg_uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt <= DIV_W'(1)) begin
      cnt  <= div;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - DIV_W'(1);
      tick <= 1'b0;
    end
  end

  AST_NO_TICK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (div == '0) |=> !tick); // R1

endmodule

// File: rtl/dbg_uart_tx.sv
module dbg_uart_tx
  import dbg_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              enable,
  input  logic              tick,
  input  logic [2:0]        par_mode,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ready,
  output logic              line
);

  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  frame_st_e         state;
  logic [DATA_W-1:0] hold_q, shreg;
  logic              hold_full;
  logic [CNT_W-1:0]  sub;
  logic [BIT_W-1:0]  bitn;
  logic              par_q, pen_q;
  logic              bit_end;

  assign bit_end = tick && (sub == CNT_W'(OVS - 1));
  assign ready   = ~hold_full;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state     <= FR_IDLE;
      hold_q    <= '0;
      shreg     <= '0;
      hold_full <= 1'b0;
      sub       <= '0;
      bitn      <= '0;
      par_q     <= 1'b0;
      pen_q     <= 1'b0;
      line      <= 1'b1;
    end else begin
      if (wr && !hold_full) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end
      if (state != FR_IDLE && tick)
        sub <= bit_end ? '0 : sub + CNT_W'(1);
      case (state)
        FR_IDLE: begin
          line <= 1'b1;
          if (tick && enable && hold_full) begin
            shreg     <= hold_q;
            par_q     <= par_value(par_mode, ^hold_q);
            pen_q     <= par_enabled(par_mode);
            hold_full <= 1'b0;
            sub       <= '0;
            bitn      <= '0;
            line      <= 1'b0;
            state     <= FR_START;
          end
        end
        FR_START: begin
          if (bit_end) begin
            line  <= shreg[0];
            shreg <= shreg >> 1;
            state <= FR_DATA;
          end
        end
        FR_DATA: begin
          if (bit_end) begin
            if (bitn == BIT_W'(DATA_W - 1)) begin
              bitn  <= '0;
              line  <= pen_q ? par_q : 1'b1;
              state <= pen_q ? FR_PAR : FR_STOP;
            end else begin
              bitn  <= bitn + BIT_W'(1);
              line  <= shreg[0];
              shreg <= shreg >> 1;
            end
          end
        end
        FR_PAR: begin
          if (bit_end) begin
            line  <= 1'b1;
            state <= FR_STOP;
          end
        end
        default: begin
          if (bit_end) begin
            line  <= 1'b1;
            state <= FR_IDLE;
          end
        end
      endcase
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == FR_IDLE && $past(state) == FR_IDLE) |-> line); // R2

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == FR_START) |-> !line); // R2

endmodule

// File: rtl/dbg_uart_rx.sv
module dbg_uart_rx
  import dbg_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              enable,
  input  logic              tick,
  input  logic              line,
  input  logic [2:0]        par_mode,
  input  logic              rd,
  input  logic              sts_clr,
  output logic [DATA_W-1:0] data,
  output logic              rdy,
  output logic              ovr,
  output logic              frm_err,
  output logic              par_err
);

  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int MID   = OVS / 2 - 1;

  frame_st_e         state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  sub;
  logic [BIT_W-1:0]  bitn;
  logic              prev, par_s, pen_q;
  logic              bit_end, commit;

  assign bit_end = tick && (sub == CNT_W'(OVS - 1));
  assign commit  = bit_end && (state == FR_STOP);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state   <= FR_IDLE;
      shreg   <= '0;
      sub     <= '0;
      bitn    <= '0;
      prev    <= 1'b1;
      par_s   <= 1'b0;
      pen_q   <= 1'b0;
      data    <= '0;
      rdy     <= 1'b0;
      ovr     <= 1'b0;
      frm_err <= 1'b0;
      par_err <= 1'b0;
    end else begin
      if (sts_clr) begin
        ovr     <= 1'b0;
        frm_err <= 1'b0;
        par_err <= 1'b0;
      end
      if (rd) rdy <= 1'b0;
      if (tick) prev <= line;
      if (!enable) begin
        state <= FR_IDLE;
      end else if (tick) begin
        case (state)
          FR_IDLE: begin
            if (prev && !line) begin
              sub   <= '0;
              pen_q <= par_enabled(par_mode);
              state <= FR_START;
            end
          end
          FR_START: begin
            if (sub == CNT_W'(MID)) begin
              sub   <= '0;
              bitn  <= '0;
              state <= line ? FR_IDLE : FR_DATA;
            end else begin
              sub <= sub + CNT_W'(1);
            end
          end
          FR_DATA: begin
            sub <= bit_end ? '0 : sub + CNT_W'(1);
            if (bit_end) begin
              shreg <= {line, shreg[DATA_W-1:1]};
              if (bitn == BIT_W'(DATA_W - 1))
                state <= pen_q ? FR_PAR : FR_STOP;
              else
                bitn <= bitn + BIT_W'(1);
            end
          end
          FR_PAR: begin
            sub <= bit_end ? '0 : sub + CNT_W'(1);
            if (bit_end) begin
              par_s <= line;
              state <= FR_STOP;
            end
          end
          default: begin
            sub <= bit_end ? '0 : sub + CNT_W'(1);
            if (commit) begin
              data <= shreg;
              rdy  <= 1'b1;
              if (rdy && !rd) ovr <= 1'b1;
              if (!line) frm_err <= 1'b1;
              if (pen_q && (par_s != par_value(par_mode, ^shreg))) par_err <= 1'b1;
              state <= FR_IDLE;
            end
          end
        endcase
      end
    end
  end

  AST_RXRDY_CLR: assert property (@(posedge clk) disable iff (rst)
    (rd && state != FR_STOP) |=> !rdy); // R4

  AST_NO_OVERRUN_LOSS: assert property (@(posedge clk) disable iff (rst)
    (commit && enable && rdy && !rd && !soft_rst) |=> ovr); // R7

endmodule

// File: rtl/dbg_uart.sv
module dbg_uart
  import dbg_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [2:0]        cfg_par,
  input  logic [1:0]        cfg_chan,
  input  logic [4:0]        irq_mask,
  input  logic [6:0]        cmd,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic [4:0]        status,
  output logic              irq,
  input  logic              rxd,
  output logic              txd
);

  logic tick;
  logic rx_en, tx_en;
  logic rxd_m, rxd_s, rx_line;
  logic tx_line, tx_ready;
  logic rx_rdy, ovr, frm_err, par_err;

  // direction enables; reset and disable take precedence over enable
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
    end else begin
      if (cmd[CMD_RX_RST] || cmd[CMD_RX_DIS]) rx_en <= 1'b0;
      else if (cmd[CMD_RX_EN])                rx_en <= 1'b1;
      if (cmd[CMD_TX_RST] || cmd[CMD_TX_DIS]) tx_en <= 1'b0;
      else if (cmd[CMD_TX_EN])                tx_en <= 1'b1;
    end
  end

  // pin synchroniser and routing
  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_m   <= 1'b1;
      rxd_s   <= 1'b1;
      rx_line <= 1'b1;
      txd     <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
      case (cfg_chan)
        CH_LOCAL:  begin rx_line <= tx_line; txd <= 1'b1;    end
        CH_REMOTE: begin rx_line <= 1'b1;    txd <= rxd_s;   end
        CH_ECHO:   begin rx_line <= rxd_s;   txd <= rxd_s;   end
        default:   begin rx_line <= rxd_s;   txd <= tx_line; end
      endcase
    end
  end

  dbg_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .div  (cfg_div),
    .tick (tick)
  );

  dbg_uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (cmd[CMD_TX_RST]),
    .enable   (tx_en),
    .tick     (tick),
    .par_mode (cfg_par),
    .wr       (tx_wr),
    .wr_data  (tx_data),
    .ready    (tx_ready),
    .line     (tx_line)
  );

  dbg_uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (cmd[CMD_RX_RST]),
    .enable   (rx_en),
    .tick     (tick),
    .line     (rx_line),
    .par_mode (cfg_par),
    .rd       (rx_rd),
    .sts_clr  (cmd[CMD_ST_CLR]),
    .data     (rx_data),
    .rdy      (rx_rdy),
    .ovr      (ovr),
    .frm_err  (frm_err),
    .par_err  (par_err)
  );

  always_comb begin
    status           = '0;
    status[ST_RXRDY] = rx_rdy;
    status[ST_TXRDY] = tx_ready;
    status[ST_OVR]   = ovr;
    status[ST_FRM]   = frm_err;
    status[ST_PAR]   = par_err;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & irq_mask);
  end

  AST_LOCAL_TXD_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_chan) == CH_LOCAL) |-> txd); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_mask) == '0) |-> !irq); // R12

  AST_RX_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !rx_rdy) |=> !rx_rdy); // R10

endmodule

// File: tb/dbg_uart_tb.sv
module dbg_uart_tb;

  localparam logic [6:0] C_RXRST = 7'h01, C_TXRST = 7'h02, C_RXEN = 7'h04,
                         C_RXDIS = 7'h08, C_TXEN = 7'h10, C_TXDIS = 7'h20,
                         C_STCLR = 7'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_div = 16'd1;
  logic [2:0]  cfg_par = 3'd4;
  logic [1:0]  cfg_chan = 2'd0;
  logic [4:0]  irq_mask = 5'd0;
  logic [6:0]  cmd = 7'd0;
  logic        tx_wr = 1'b0;
  logic [7:0]  tx_data = 8'd0;
  logic        rx_rd = 1'b0;
  logic [7:0]  rx_data;
  logic [4:0]  status;
  logic        irq;
  logic        rxd = 1'b1;
  logic        txd;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  int  bitlen = 16;

  always #4 clk = ~clk;

  dbg_uart u_dut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_par(cfg_par),
    .cfg_chan(cfg_chan), .irq_mask(irq_mask), .cmd(cmd), .tx_wr(tx_wr),
    .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data), .status(status),
    .irq(irq), .rxd(rxd), .txd(txd)
  );

  function automatic bit f_pen(input logic [2:0] m);
    return m < 3'd4;
  endfunction

  function automatic logic f_par(input logic [2:0] m, input logic [7:0] d);
    case (m)
      3'd0: return ^d;
      3'd1: return ~(^d);
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic command(input logic [6:0] c);
    @(negedge clk) cmd = c;
    @(negedge clk) cmd = 7'd0;
  endtask

  task automatic write_tx(input logic [7:0] d);
    @(negedge clk) begin tx_wr = 1'b1; tx_data = d; end
    @(negedge clk) tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk) rx_rd = 1'b1;
    @(negedge clk) rx_rd = 1'b0;
  endtask

  task automatic drive_frame(input logic [7:0] d, input logic [2:0] m,
                             input bit bad_par, input bit bad_stop);
    @(negedge clk) rxd = 1'b0;
    repeat (bitlen) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      rxd = d[b];
      repeat (bitlen) @(negedge clk);
    end
    if (f_pen(m)) begin
      rxd = f_par(m, d) ^ bad_par;
      repeat (bitlen) @(negedge clk);
    end
    rxd = ~bad_stop;
    repeat (bitlen) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bitlen) @(negedge clk);
  endtask

  task automatic capture_tx(input bit pen, output logic [7:0] d, output logic pb,
                            output logic sb, output bit ok);
    ok = 1'b0; d = '0; pb = 1'b0; sb = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (txd == 1'b0) begin ok = 1'b1; break; end
    end
    if (!ok) return;
    repeat (bitlen / 2) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      repeat (bitlen) @(negedge clk);
      d[b] = txd;
    end
    if (pen) begin
      repeat (bitlen) @(negedge clk);
      pb = txd;
    end
    repeat (bitlen) @(negedge clk);
    sb = txd;
    repeat (bitlen / 2 + 4) @(negedge clk);
  endtask

  task automatic watch_high(input int n, output bit stayed);
    stayed = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) stayed = 1'b0;
    end
  endtask

  task automatic tx_round(input logic [7:0] d, input string tag);
    logic [7:0] cd; logic pb, sb; bit ok;
    write_tx(d);
    capture_tx(f_pen(cfg_par), cd, pb, sb, ok);
    chk({tag, " frame seen"}, ok, 1);
    chk({tag, " data"}, cd, d);
    if (f_pen(cfg_par)) chk({tag, " R3 parity bit"}, pb, f_par(cfg_par, d));
    chk({tag, " stop bit"}, sb, 1);
    chk({tag, " R2 tx ready after frame"}, status[1], 1);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2, cd;
    logic [2:0] m;
    logic pb, sb;
    bit ok, stayed;
    int unsigned seed;
    seed = $urandom(32'h5EED1234);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk("R13 txd idle", txd, 1);
    chk("R13 status", status, 5'b00010);
    chk("R13 irq", irq, 0);

    // R10: reset-disabled receiver ignores a frame
    drive_frame(8'hA5, 3'd4, 0, 0);
    chk("R10 rx disabled after reset", status[0], 0);

    command(C_RXEN | C_TXEN);

    // R4/R3 normal receive, random data and parity modes
    for (int k = 0; k < 7; k++) begin
      d = 8'($urandom);
      m = (k == 6) ? 3'd7 : 3'($urandom % 5);
      cfg_par = m;
      drive_frame(d, m, 0, 0);
      chk("R4 rx data", rx_data, d);
      chk("R4 rx ready set", status[0], 1);
      chk("R3 no parity error", status[4], 0);
      chk("R5 no framing error", status[3], 0);
      read_rx();
      chk("R4 rx ready cleared by read", status[0], 0);
    end

    // R2/R3 normal transmit
    for (int k = 0; k < 6; k++) begin
      cfg_par = (k < 5) ? 3'(k) : 3'd6;
      tx_round(8'($urandom), "R2 tx");
    end
    // directed corner values
    cfg_par = 3'd0; tx_round(8'h00, "R2 tx zero");
    cfg_par = 3'd1; tx_round(8'hFF, "R2 tx ones");

    // R1 baud divisor 3
    cfg_div = 16'd3; bitlen = 48; cfg_par = 3'd4;
    tx_round(8'h4B, "R1 div3 tx");
    drive_frame(8'hC3, 3'd4, 0, 0);
    chk("R1 div3 rx data", rx_data, 8'hC3);
    read_rx();

    // R1 divisor 0 freezes the transmitter
    cfg_div = 16'd0;
    write_tx(8'h3C);
    watch_high(400, stayed);
    chk("R1 div0 txd stays high", stayed, 1);
    chk("R1 div0 char held", status[1], 0);
    cfg_div = 16'd1; bitlen = 16;
    capture_tx(0, cd, pb, sb, ok);
    chk("R1 resumed frame data", cd, 8'h3C);

    // R6 parity error, R11 clear
    cfg_par = 3'd0;
    drive_frame(8'h96, 3'd0, 1, 0);
    chk("R6 parity error flag", status[4], 1);
    chk("R6 data still delivered", rx_data, 8'h96);
    read_rx();
    command(C_STCLR);
    chk("R11 parity flag cleared", status[4], 0);

    // R5 framing error
    cfg_par = 3'd4;
    drive_frame(8'h5A, 3'd4, 0, 1);
    chk("R5 framing error flag", status[3], 1);
    chk("R5 data delivered", rx_data, 8'h5A);
    read_rx();
    command(C_STCLR);
    chk("R11 framing flag cleared", status[3], 0);

    // R7 overrun
    drive_frame(8'h11, 3'd4, 0, 0);
    drive_frame(8'h22, 3'd4, 0, 0);
    chk("R7 overrun flag", status[2], 1);
    chk("R7 newest char kept", rx_data, 8'h22);

    // R12 interrupt masking
    irq_mask = 5'b00000; repeat (2) @(negedge clk);
    chk("R12 irq masked off", irq, 0);
    irq_mask = 5'b00100; repeat (2) @(negedge clk);
    chk("R12 irq on overrun", irq, 1);
    read_rx();
    command(C_STCLR);
    chk("R11 overrun flag cleared", status[2], 0);
    irq_mask = 5'b11001; repeat (2) @(negedge clk);
    chk("R12 irq quiet with no flags", irq, 0);
    irq_mask = 5'b00010; repeat (2) @(negedge clk);
    chk("R12 irq on tx ready", irq, 1);
    irq_mask = 5'b00000;

    // R8 local loopback, rxd held low
    cfg_chan = 2'd2; rxd = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      d = 8'($urandom);
      cfg_par = 3'($urandom % 5);
      write_tx(d);
      watch_high(240, stayed);
      chk("R8 txd held high", stayed, 1);
      chk("R8 looped data", rx_data, d);
      chk("R8 loop no errors", status[4:2], 3'b000);
      read_rx();
    end
    rxd = 1'b1; repeat (4) @(negedge clk);
    cfg_chan = 2'd0; cfg_par = 3'd4;
    repeat (4) @(negedge clk);

    // R9 remote loopback
    cfg_chan = 2'd3;
    @(negedge clk) rxd = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 remote low follows", txd, 0);
    rxd = 1'b1; repeat (6) @(negedge clk);
    chk("R9 remote high follows", txd, 1);
    drive_frame(8'h77, 3'd4, 0, 0);
    chk("R9 remote receiver idle", status[0], 0);

    // R9 echo
    cfg_chan = 2'd1; repeat (4) @(negedge clk);
    d2 = 8'($urandom);
    fork
      drive_frame(d2, 3'd4, 0, 0);
      capture_tx(0, cd, pb, sb, ok);
    join
    chk("R9 echo on txd", cd, d2);
    chk("R9 echo receiver works", rx_data, d2);
    read_rx();
    cfg_chan = 2'd0; repeat (4) @(negedge clk);

    // R10 commands
    command(C_RXDIS);
    drive_frame(8'h0F, 3'd4, 0, 0);
    chk("R10 rx disabled ignores frame", status[0], 0);
    command(C_RXEN | C_RXDIS);
    drive_frame(8'hF0, 3'd4, 0, 0);
    chk("R10 disable wins over enable", status[0], 0);
    command(C_RXEN);
    drive_frame(8'hE1, 3'd4, 0, 0);
    chk("R10 rx re-enabled", rx_data, 8'hE1);
    command(C_RXRST);
    chk("R10 rx reset clears ready", status[0], 0);
    command(C_RXEN);

    command(C_TXDIS);
    write_tx(8'h81);
    watch_high(300, stayed);
    chk("R10 tx disabled keeps txd high", stayed, 1);
    chk("R10 tx disabled holds char", status[1], 0);
    command(C_TXEN);
    capture_tx(0, cd, pb, sb, ok);
    chk("R10 tx sends held char", cd, 8'h81);
    command(C_TXDIS);
    write_tx(8'h42);
    command(C_TXRST);
    chk("R10 tx reset frees holding reg", status[1], 1);
    command(C_TXEN);
    watch_high(300, stayed);
    chk("R10 tx reset dropped char", stayed, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule